// File: doc/BRIEF.md
# Supply Interruption Test Sequencer

This block produces the two control lines for a bench tester that subjects a device's DC supply to timed interruptions and half-voltage dips. One line, the dip output, disconnects the full supply path when it is active. The other line, the half output, switches in a reduced-voltage rail. Together they produce three repeating test patterns. The block sees the external switches only through these two lines.

A single push button selects the pattern. The selection cycles through four states: ST_OFF, ST_T1, ST_T2 and ST_T3. Each accepted press takes the transition ADVANCE to the next state in that order, and ST_T3 wraps back to ST_OFF. A status LED blinks once for each step of the newly selected test number, so the operator can see which test is running.

A periodic tick enable sets the time base: one tick is 10 µs, so 1000 ticks give 10 ms. Inside the block, a period counter with two compare points produces the waveform. The counter restarts from zero on every state change. The outputs stay inactive until the first tick after the change.

Top module: `supply_dip_sequencer`

## Requirements
- R1: Each accepted press advances the selection by one step along ST_OFF→ST_T1→ST_T2→ST_T3→ST_OFF. A rising level on the button input, which is active high, counts as a press.
- R2: In ST_OFF, the dip output and the half output are both held low.
- R3: On entry to test state N (N = 1, 2 or 3), the LED output gives exactly N flashes. Each flash is FLASH_TICKS ticks on followed by FLASH_TICKS ticks off. Entry to ST_OFF gives no flash, and the LED stays dark there.
- R4: Once a press is accepted, any further press within the next DEBOUNCE_TICKS ticks is ignored.
- R5: ST_T1 has a 1000-tick period. The dip output is high for the first 110 ticks of each period, and the half output never goes high.
- R6: ST_T2 has a 2000-tick period. In each period the dip output is high for the first 200 ticks and the half output is high for the first 210 ticks.
- R7: ST_T3 has a 50000-tick period. In each period the dip output is high for the first 5000 ticks and the half output is high for the first 5010 ticks.
- R8: In ST_T2 and ST_T3, the half output is high whenever the dip output is high. After the dip output falls, the half output stays high for a further 10 ticks.
- R9: On any state change, the period counter restarts at zero. Both outputs stay low until the first tick after the change, and a period begins with that tick.
- R10: While reset is active, and after its release with no press, the dip, half and LED outputs are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| btn_raw | input | 1 | Unsynchronised push button, high when pressed |
| tick | input | 1 | Time-base enable, one pulse per 10 µs |
| dip_out | output | 1 | High removes the full supply path |
| half_out | output | 1 | High selects the half-voltage rail |
| led_out | output | 1 | Status LED, high for on |

## Verification
The assertions check, on every cycle, the properties that hold at all times:
- the selection only ever steps forward by one state;
- both outputs are quiet in ST_OFF;
- the half output never appears in ST_T1;
- the half output covers the dip output and falls only after the dip has already dropped;
- the counter is zero, with both outputs low, right after a reload;
- the LED is dark in ST_OFF;
- no accepted press follows directly on another.

Only the bench scenarios can show the things that need a run through whole periods or a sequence of operations:
- the exact high and low widths in each profile;
- the 10-tick guard tail;
- the number of LED flashes;
- a bounced press being swallowed by the lockout;
- the outputs held off while the tick is stalled.

// File: rtl/sds_pkg.sv
package sds_pkg;

    typedef enum logic [1:0] {
        ST_OFF = 2'd0,
        ST_T1  = 2'd1,
        ST_T2  = 2'd2,
        ST_T3  = 2'd3
    } test_sel_e;

endpackage

// File: rtl/sds_press.sv
module sds_press #(
    parameter int LOCK_TICKS = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic btn_raw,
    output logic accept
);
    localparam int LW = $clog2(LOCK_TICKS + 1);

    logic          s1, s2, s3;
    logic [LW-1:0] lock;
    logic          press;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= btn_raw;
            s2 <= s1;
            s3 <= s2;
        end
    end

    always_comb begin
        press  = s2 & ~s3;
        accept = press && (lock == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            lock <= '0;
        else if (accept)
            lock <= LW'(LOCK_TICKS);
        else if (tick && lock != '0)
            lock <= lock - 1'b1;
    end

    AST_LOCKOUT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept); // R4

endmodule

// File: rtl/sds_sel_fsm.sv
module sds_sel_fsm
    import sds_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      adv,
    output test_sel_e sel,
    output test_sel_e sel_nx
);

    always_comb begin
        sel_nx = sel;
        if (adv) begin
            unique case (sel)
                ST_OFF: sel_nx = ST_T1;
                ST_T1:  sel_nx = ST_T2;
                ST_T2:  sel_nx = ST_T3;
                ST_T3:  sel_nx = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            sel <= ST_OFF;
        else
            sel <= sel_nx;
    end

    AST_SEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != $past(sel)) |-> (2'(sel) == 2'(2'($past(sel)) + 2'd1))); // R1

endmodule

// File: rtl/sds_wave.sv
module sds_wave
    import sds_pkg::*;
#(
    parameter int P1_PER  = 1000,
    parameter int P1_DIP  = 110,
    parameter int P1_HALF = 0,
    parameter int P2_PER  = 2000,
    parameter int P2_DIP  = 200,
    parameter int P2_HALF = 210,
    parameter int P3_PER  = 50000,
    parameter int P3_DIP  = 5000,
    parameter int P3_HALF = 5010,
    parameter int CW      = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      load,
    input  test_sel_e sel,
    output logic      dip,
    output logic      half
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] last;
    logic [CW-1:0] cmp_d;
    logic [CW-1:0] cmp_h;
    logic          hold;

    always_comb begin
        unique case (sel)
            ST_OFF: begin last = '0;            cmp_d = '0;         cmp_h = '0;          end
            ST_T1:  begin last = CW'(P1_PER-1); cmp_d = CW'(P1_DIP); cmp_h = CW'(P1_HALF); end
            ST_T2:  begin last = CW'(P2_PER-1); cmp_d = CW'(P2_DIP); cmp_h = CW'(P2_HALF); end
            ST_T3:  begin last = CW'(P3_PER-1); cmp_d = CW'(P3_DIP); cmp_h = CW'(P3_HALF); end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            hold <= 1'b0;
        end else if (load) begin
            cnt  <= '0;
            hold <= 1'b1;
        end else if (tick) begin
            if (hold)
                hold <= 1'b0;
            else if (cnt >= last)
                cnt <= '0;
            else
                cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        dip  = (sel != ST_OFF) && !hold && (cnt < cmp_d);
        half = (sel != ST_OFF) && !hold && (cnt < cmp_h);
    end

    AST_OFF_QUIET:   assert property (@(posedge clk) disable iff (!rst_n)
        (sel == ST_OFF) |-> (!dip && !half)); // R2
    AST_T1_NO_HALF:  assert property (@(posedge clk) disable iff (!rst_n)
        (sel == ST_T1) |-> !half); // R5
    AST_HALF_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel == ST_T2 || sel == ST_T3) && dip) |-> half); // R8
    AST_HALF_TAIL:   assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(half) && !hold && $stable(sel)) |-> !$past(dip)); // R8
    AST_RELOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == '0 && !dip && !half)); // R9

endmodule

// File: rtl/sds_blink.sv
module sds_blink #(
    parameter int FLASH_TICKS = 25000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       load,
    input  logic [1:0] count,
    output logic       led
);
    localparam int FW = $clog2(FLASH_TICKS + 1);

    logic [1:0]    left;
    logic          on;
    logic [FW-1:0] tc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left <= 2'd0;
            on   <= 1'b0;
            tc   <= '0;
        end else if (load) begin
            left <= count;
            on   <= (count != 2'd0);
            tc   <= '0;
        end else if (tick && left != 2'd0) begin
            if (tc == FW'(FLASH_TICKS - 1)) begin
                tc <= '0;
                if (on) begin
                    on   <= 1'b0;
                    left <= left - 2'd1;
                end else begin
                    on <= 1'b1;
                end
            end else begin
                tc <= tc + 1'b1;
            end
        end
    end

    always_comb led = on;

    AST_LED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (left == 2'd0 && !load) |=> !led); // R3

endmodule

// File: rtl/supply_dip_sequencer.sv
module supply_dip_sequencer
    import sds_pkg::*;
#(
    parameter int DEBOUNCE_TICKS = 20000,
    parameter int FLASH_TICKS    = 25000,
    parameter int P1_PER         = 1000,
    parameter int P1_DIP         = 110,
    parameter int P1_HALF        = 0,
    parameter int P2_PER         = 2000,
    parameter int P2_DIP         = 200,
    parameter int P2_HALF        = 210,
    parameter int P3_PER         = 50000,
    parameter int P3_DIP         = 5000,
    parameter int P3_HALF        = 5010
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_raw,
    input  logic tick,
    output logic dip_out,
    output logic half_out,
    output logic led_out
);
    localparam int MAX12 = (P1_PER > P2_PER) ? P1_PER : P2_PER;
    localparam int MAXP  = (MAX12 > P3_PER) ? MAX12 : P3_PER;
    localparam int CW    = $clog2(MAXP + 1);

    logic      adv;
    test_sel_e sel;
    test_sel_e sel_nx;
    logic      load;

    sds_press #(.LOCK_TICKS(DEBOUNCE_TICKS)) u_press (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .btn_raw (btn_raw),
        .accept  (adv)
    );

    sds_sel_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (adv),
        .sel    (sel),
        .sel_nx (sel_nx)
    );

    always_comb load = adv;

    sds_wave #(
        .P1_PER(P1_PER), .P1_DIP(P1_DIP), .P1_HALF(P1_HALF),
        .P2_PER(P2_PER), .P2_DIP(P2_DIP), .P2_HALF(P2_HALF),
        .P3_PER(P3_PER), .P3_DIP(P3_DIP), .P3_HALF(P3_HALF),
        .CW(CW)
    ) u_wave (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .load  (load),
        .sel   (sel),
        .dip   (dip_out),
        .half  (half_out)
    );

    sds_blink #(.FLASH_TICKS(FLASH_TICKS)) u_blink (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .load  (load),
        .count (2'(sel_nx)),
        .led   (led_out)
    );

    AST_LED_DARK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == ST_OFF) |-> !led_out); // R3
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!dip_out && !half_out && !led_out)); // R10

endmodule

// File: tb/test_supply_dip_sequencer.sv
`timescale 1ns/1ps
module test_supply_dip_sequencer;
    localparam int DEB = 40;
    localparam int FL  = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic btn_raw = 1'b0;
    logic tick = 1'b1;
    logic dip_out, half_out, led_out;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    supply_dip_sequencer #(.DEBOUNCE_TICKS(DEB), .FLASH_TICKS(FL)) i_supply_dip_sequencer (
        .clk(clk), .rst_n(rst_n), .btn_raw(btn_raw), .tick(tick),
        .dip_out(dip_out), .half_out(half_out), .led_out(led_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Press (optionally bounced) and count LED flashes that follow
    task automatic press_count(input bit bounce, output int n);
        logic prev;
        n = 0;
        @(negedge clk);
        prev = led_out;
        for (int i = 0; i < 220; i++) begin
            btn_raw = (i < 4) || (bounce && i >= 8 && i < 12);
            @(negedge clk);
            if (led_out && !prev) n++;
            prev = led_out;
        end
        btn_raw = 1'b0;
    endtask

    function automatic logic sig(input bit use_half);
        return use_half ? half_out : dip_out;
    endfunction

    task automatic meas(input bit use_half, output int hi, output int lo);
        int g;
        hi = 0; lo = 0; g = 0;
        while (sig(use_half) == 1'b1 && g < 60000) begin @(negedge clk); g++; end
        while (sig(use_half) == 1'b0 && g < 120000) begin @(negedge clk); g++; end
        while (sig(use_half) == 1'b1 && g < 180000) begin @(negedge clk); hi++; g++; end
        while (sig(use_half) == 1'b0 && g < 240000) begin @(negedge clk); lo++; g++; end
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        chk(!dip_out && !half_out, "R10 outputs in reset", {dip_out, half_out}, 0);
        rst_n = 1'b1;
        repeat (50) @(negedge clk);
        chk(!dip_out && !half_out, "R10 outputs after reset", {dip_out, half_out}, 0);
        chk(!led_out, "R10 led after reset", led_out, 0);
    endtask

    task automatic t_test1();
        int n, hi, lo, bad;
        press_count(1'b1, n);
        chk(n == 1, "R1 R4 bounced press gives one step to T1 flashes", n, 1);
        meas(1'b0, hi, lo);
        chk(hi == 110, "R5 T1 dip high width", hi, 110);
        chk(lo == 890, "R5 T1 dip low width", lo, 890);
        bad = 0;
        for (int i = 0; i < 1000; i++) begin @(negedge clk); if (half_out) bad++; end
        chk(bad == 0, "R5 T1 half never high", bad, 0);
    endtask

    task automatic t_test2();
        int n, hi, lo, hhi, hlo, bad;
        press_count(1'b0, n);
        chk(n == 2, "R3 T2 flash count", n, 2);
        meas(1'b0, hi, lo);
        chk(hi == 200, "R6 T2 dip high width", hi, 200);
        chk(lo == 1800, "R6 T2 dip low width", lo, 1800);
        meas(1'b1, hhi, hlo);
        chk(hhi == 210, "R6 T2 half high width", hhi, 210);
        chk(hlo == 1790, "R6 T2 half low width", hlo, 1790);
        chk(hhi - hi == 10, "R8 half guard tail", hhi - hi, 10);
        bad = 0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (dip_out && !half_out) bad++;
        end
        chk(bad == 0, "R8 half covers dip", bad, 0);
    endtask

    task automatic t_test3_stall();
        int dh, hh, g;
        @(negedge clk);
        tick = 1'b0;
        for (int i = 0; i < 4; i++) begin btn_raw = 1'b1; @(negedge clk); end
        btn_raw = 1'b0;
        repeat (10) @(negedge clk);
        chk(led_out, "R3 T3 entry lights led", led_out, 1);
        chk(!dip_out && !half_out, "R9 outputs held until tick", {dip_out, half_out}, 0);
        tick = 1'b1;
        @(negedge clk);
        chk(dip_out && half_out, "R9 period starts after first tick", {dip_out, half_out}, 3);
        dh = 0; hh = 0; g = 0;
        while ((dip_out || half_out) && g < 6000) begin
            if (dip_out) dh++;
            if (half_out) hh++;
            @(negedge clk);
            g++;
        end
        chk(dh == 5000, "R7 T3 dip high width", dh, 5000);
        chk(hh == 5010, "R7 T3 half high width", hh, 5010);
        repeat (200) @(negedge clk);
    endtask

    task automatic t_off();
        int n, bad;
        press_count(1'b0, n);
        chk(n == 0, "R3 R1 no flash on return to OFF", n, 0);
        bad = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (dip_out || half_out || led_out) bad++;
        end
        chk(bad == 0, "R2 OFF outputs quiet", bad, 0);
    endtask

    initial begin
        t_reset();
        t_test1();
        t_test2();
        t_test3_stall();
        t_off();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            vectors++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule